// File: doc/BRIEF.md
# Serial Debug Device Command Decoder

This block is the device end of one select line on a serial expansion channel. The channel engine hands it immediate transfers: a 32-bit word with a direction and a byte count of one to four. It also hands it DMA read requests, each carrying a 32-bit offset and a length. The decoder recognises a few command words and offsets and ignores everything else.

A write of the arming word puts the decoder into console mode. Each later write in that mode is unpacked into one to four text bytes, highest byte first. The bytes leave on an 8-bit valid/ready stream. A four-byte holding buffer stalls the engine until the stream has taken every byte. The mode is sticky and ends only when the select line drops. At that point a one-cycle flush strobe marks the end of the text. An immediate read of the query word loads a fixed status reply into the read-data register.

On the DMA side, one offset is recognised as an SRAM read and raises a one-cycle strobe. Offsets inside the font window are converted to a byte index. The block then streams the requested number of bytes from an external font memory port and pulses a done strobe after the last byte.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After reset the decoder is idle. `xfer_ready` and `dma_ready` are 1. `con_valid`, `con_flush`, `sram_req`, `font_rd_en`, `fill_valid` and `dma_done` are 0, and `rd_data` is 0.
- R2: An accepted write (`xfer_write`=1) of 0xA0010000 with `sel`=1 enters console mode and emits no console byte. Repeating it while in console mode also emits nothing.
- R3: In console mode, an accepted write of any other word emits `xfer_size`+1 bytes. `xfer_size` codes 0..3 mean 1..4 bytes. The order is data[31:24] first, then data[23:16], data[15:8] and data[7:0], cut after the given count.
- R4: `xfer_ready` is 0 while any console byte is still held, so a transfer is only accepted with the buffer empty. While `con_valid`=1 and `con_ready`=0, `con_data` and `con_valid` hold.
- R5: When `sel` is 0 at a clock edge in console mode, `con_flush` pulses for exactly one cycle and the decoder returns to idle. Later writes emit nothing until it is re-armed.
- R6: In idle mode, writes of words other than the arming word emit no console byte.
- R7: An accepted read (`xfer_write`=0) of 0x20010000 with `sel`=1 sets `rd_data` to 0x03000000 from the next cycle. Any other read leaves `rd_data` unchanged.
- R8: An accepted DMA request with offset 0x20000100 pulses `sram_req` for one cycle and causes no font read.
- R9: An accepted DMA request with offset in [0x06BFC000, 0x07FFC000) and nonzero `dma_len` reads `dma_len` consecutive font addresses. The reads start at (offset>>6)-0x1AFF00, one per cycle on `font_rd_en`/`font_addr`. Each read's data, taken from `font_rd_data` one cycle later, appears on `fill_data` with `fill_valid`.
- R10: `dma_done` pulses once, in the cycle after the last `fill_valid`. `dma_ready` stays 0 from acceptance until after the done pulse.
- R11: DMA requests with any other offset, or with a font offset and `dma_len`=0, produce no `sram_req`, no font read, no fill byte and no done pulse.
- R12: Immediate transfers while `sel`=0 change nothing: they do not arm the decoder, emit no bytes and do not change `rd_data`.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Device select from the channel |
| xfer_valid | input | 1 | Immediate transfer strobe |
| xfer_write | input | 1 | 1 = write, 0 = read |
| xfer_size | input | 2 | Byte count minus one |
| xfer_data | input | 32 | Immediate data or command word |
| xfer_ready | output | 1 | Transfer accepted when high together with valid |
| rd_data | output | 32 | Immediate read reply register |
| con_valid | output | 1 | Console byte available |
| con_data | output | 8 | Console byte |
| con_ready | input | 1 | Console sink accepts byte |
| con_flush | output | 1 | End-of-text strobe on deselect |
| dma_req | input | 1 | DMA read request strobe |
| dma_offset | input | 32 | DMA device offset |
| dma_len | input | LEN_W | DMA byte count |
| dma_ready | output | 1 | DMA request accepted when high |
| sram_req | output | 1 | SRAM read request strobe |
| font_rd_en | output | 1 | Font memory read enable |
| font_addr | output | 19 | Font memory byte address |
| font_rd_data | input | 8 | Font memory data, one cycle after enable |
| fill_valid | output | 1 | Font byte valid |
| fill_data | output | 8 | Font byte |
| dma_done | output | 1 | Font stream finished |

## Verification
Console unpacking and font streaming run on separate paths and can be active in the same cycles. The bench starts a font read of several bytes while console writes are still draining through a randomly throttled `con_ready`. One scoreboard queue holds the expected console bytes and a second holds the expected font addresses and fill bytes. Each queue is popped only by its own output, so any crosstalk between the paths, such as a stalled stream or a skipped or repeated byte, shows as a miscompare on one side.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [31:0] ARM_WORD    = 32'hA001_0000;
  localparam logic [31:0] QUERY_WORD  = 32'h2001_0000;
  localparam logic [31:0] QUERY_REPLY = 32'h0300_0000;
  localparam logic [31:0] SRAM_OFFSET = 32'h2000_0100;
  localparam logic [25:0] FONT_BASE   = 26'h1A_FF00;
  localparam logic [25:0] FONT_END    = 26'h1F_FF00;
  localparam int FONT_BYTES = 32'h5_0000;
  localparam int FONT_AW    = $clog2(FONT_BYTES);
  localparam int BUF_BYTES  = 4;
  localparam int CNT_W      = $clog2(BUF_BYTES + 1);

  function automatic logic in_font_window(input logic [31:0] off);
    return (off[31:6] >= FONT_BASE) && (off[31:6] < FONT_END);
  endfunction

  function automatic logic [FONT_AW-1:0] font_index(input logic [31:0] off);
    logic [25:0] diff;
    diff = off[31:6] - FONT_BASE;
    return diff[FONT_AW-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] size_to_count(input logic [1:0] sz);
    return CNT_W'(sz) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/dbg_cmd_fsm.sv
module dbg_cmd_fsm
  import dbg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        acc,
  input  logic        write,
  input  logic [31:0] data,
  output logic        armed,
  output logic        con_load,
  output logic        flush,
  output logic [31:0] rd_data
);
  typedef enum logic {M_IDLE, M_CONSOLE} mode_t;
  mode_t mode_q, mode_d;
  logic  flush_q;
  logic [31:0] rd_q;

  wire arm_hit   = acc && sel && write && (data == ARM_WORD);
  wire query_hit = acc && sel && !write && (data == QUERY_WORD);
  wire deselect  = (mode_q == M_CONSOLE) && !sel;

  always_comb begin
    mode_d = mode_q;
    if (deselect)     mode_d = M_IDLE;
    else if (arm_hit) mode_d = M_CONSOLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_IDLE;
      flush_q <= 1'b0;
      rd_q    <= '0;
    end else begin
      mode_q  <= mode_d;
      flush_q <= deselect;
      if (query_hit) rd_q <= QUERY_REPLY;
    end
  end

  assign armed    = (mode_q == M_CONSOLE);
  assign con_load = acc && sel && write && armed && (data != ARM_WORD);
  assign flush    = flush_q;
  assign rd_data  = rd_q;

  p_deselect_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !sel) |=> (!armed && flush));
  p_flush_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  p_arm_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel && write && data == ARM_WORD) |=> armed);
  p_unselected_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(rd_data));
endmodule

// File: rtl/dbg_con_packer.sv
module dbg_con_packer
  import dbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [31:0]      word,
  output logic             empty,
  output logic             con_valid,
  output logic [7:0]       con_data,
  input  logic             con_ready
);
  logic [8*BUF_BYTES-1:0] buf_q;
  logic [CNT_W-1:0]       cnt_q;

  wire take = con_valid && con_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      buf_q <= word;
      cnt_q <= nbytes;
    end else if (take) begin
      buf_q <= {buf_q[8*BUF_BYTES-9:0], 8'h00};
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign empty     = (cnt_q == '0);
  assign con_valid = !empty;
  assign con_data  = buf_q[8*BUF_BYTES-1 -: 8];

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (con_valid && !con_ready) |=> (con_valid && $stable(con_data)));
  p_load_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> empty);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUF_BYTES));
endmodule

// File: rtl/dbg_font_stream.sv
module dbg_font_stream
  import dbg_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [31:0]        offset,
  input  logic [LEN_W-1:0]   len,
  output logic               ready,
  output logic               sram_req,
  output logic               rd_en,
  output logic [FONT_AW-1:0] addr,
  output logic               fill_valid,
  output logic               done
);
  logic               busy_q, last_q, fill_q, done_q, sram_q;
  logic [FONT_AW-1:0] addr_q;
  logic [LEN_W-1:0]   rem_q;

  wire accept    = req && ready;
  wire font_hit  = accept && in_font_window(offset) && (len != '0);
  wire sram_hit  = accept && (offset == SRAM_OFFSET);
  wire last_issue = busy_q && (rem_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      fill_q <= 1'b0;
      done_q <= 1'b0;
      sram_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      sram_q <= sram_hit;
      fill_q <= busy_q;
      last_q <= last_issue;
      done_q <= last_q;
      if (font_hit) begin
        busy_q <= 1'b1;
        addr_q <= font_index(offset);
        rem_q  <= len;
      end else if (busy_q) begin
        addr_q <= addr_q + FONT_AW'(1);
        rem_q  <= rem_q - LEN_W'(1);
        if (last_issue) busy_q <= 1'b0;
      end
    end
  end

  assign ready      = !(busy_q || fill_q || done_q);
  assign sram_req   = sram_q;
  assign rd_en      = busy_q;
  assign addr       = addr_q;
  assign fill_valid = fill_q;
  assign done       = done_q;

  p_addr_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (addr < FONT_AW'(FONT_BYTES)));
  p_done_after_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(fill_valid) && !fill_valid));
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || fill_valid) |-> !ready);
  p_sram_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_req |-> !rd_en);
endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
  import dbg_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               xfer_valid,
  input  logic               xfer_write,
  input  logic [1:0]         xfer_size,
  input  logic [31:0]        xfer_data,
  output logic               xfer_ready,
  output logic [31:0]        rd_data,
  output logic               con_valid,
  output logic [7:0]         con_data,
  input  logic               con_ready,
  output logic               con_flush,
  input  logic               dma_req,
  input  logic [31:0]        dma_offset,
  input  logic [LEN_W-1:0]   dma_len,
  output logic               dma_ready,
  output logic               sram_req,
  output logic               font_rd_en,
  output logic [FONT_AW-1:0] font_addr,
  input  logic [7:0]         font_rd_data,
  output logic               fill_valid,
  output logic [7:0]         fill_data
  ,
  output logic               dma_done
);
  logic buf_empty, con_load, armed;
  wire  xfer_acc = xfer_valid && xfer_ready;

  assign xfer_ready = buf_empty;
  assign fill_data  = font_rd_data;

  dbg_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel(sel), .acc(xfer_acc),
    .write(xfer_write), .data(xfer_data), .armed(armed),
    .con_load(con_load), .flush(con_flush), .rd_data(rd_data)
  );

  dbg_con_packer u_pack (
    .clk(clk), .rst_n(rst_n), .load(con_load),
    .nbytes(size_to_count(xfer_size)), .word(xfer_data),
    .empty(buf_empty), .con_valid(con_valid), .con_data(con_data),
    .con_ready(con_ready)
  );

  dbg_font_stream #(.LEN_W(LEN_W)) u_font (
    .clk(clk), .rst_n(rst_n), .req(dma_req), .offset(dma_offset),
    .len(dma_len), .ready(dma_ready), .sram_req(sram_req),
    .rd_en(font_rd_en), .addr(font_addr), .fill_valid(fill_valid),
    .done(dma_done)
  );

  p_idle_no_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_acc && !armed) |=> !con_valid);
  p_stall_when_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    con_valid |-> !xfer_ready);
endmodule

// File: tb/dbg_cmd_decoder_test.sv
`timescale 1ns/1ps
module dbg_cmd_decoder_test;
  localparam int LEN_W = 12;
  localparam int AW = 19;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0;
  logic xfer_valid = 1'b0, xfer_write = 1'b0;
  logic [1:0] xfer_size = '0;
  logic [31:0] xfer_data = '0;
  logic xfer_ready, con_valid, con_flush, con_ready;
  logic [31:0] rd_data;
  logic [7:0] con_data, fill_data;
  logic dma_req = 1'b0;
  logic [31:0] dma_offset = '0;
  logic [LEN_W-1:0] dma_len = '0;
  logic dma_ready, sram_req, font_rd_en, fill_valid, dma_done;
  logic [AW-1:0] font_addr;
  logic [7:0] rom_q;

  always #5 clk = ~clk;

  dbg_cmd_decoder #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .xfer_valid(xfer_valid),
    .xfer_write(xfer_write), .xfer_size(xfer_size), .xfer_data(xfer_data),
    .xfer_ready(xfer_ready), .rd_data(rd_data), .con_valid(con_valid),
    .con_data(con_data), .con_ready(con_ready), .con_flush(con_flush),
    .dma_req(dma_req), .dma_offset(dma_offset), .dma_len(dma_len),
    .dma_ready(dma_ready), .sram_req(sram_req), .font_rd_en(font_rd_en),
    .font_addr(font_addr), .font_rd_data(rom_q), .fill_valid(fill_valid),
    .fill_data(fill_data), .dma_done(dma_done)
  );

  function automatic logic [7:0] rom_f(input logic [AW-1:0] a);
    return a[7:0] ^ {a[18:15], a[11:8]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (font_rd_en) rom_q <= rom_f(font_addr);

  int applied = 0, bad = 0;
  int con_seen = 0, flush_seen = 0, sram_seen = 0, rd_seen = 0, fill_seen = 0, done_seen = 0;
  logic [7:0] con_q[$], fill_q[$];
  logic [AW-1:0] addr_q[$];
  bit armed_m = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_fill = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    con_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      con_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (con_valid && con_ready) begin
      con_seen++;
      if (con_q.size() == 0) chk(0, "R3 extra console byte", {24'h0, con_data}, 32'h0);
      else begin
        logic [7:0] e; e = con_q.pop_front();
        chk(con_data == e, "R3 console byte", {24'h0, con_data}, {24'h0, e});
      end
    end
    if (con_flush) flush_seen++;
    if (sram_req) sram_seen++;
    if (font_rd_en) begin
      rd_seen++;
      if (addr_q.size() == 0) chk(0, "R9 unexpected font read", {13'h0, font_addr}, 32'h0);
      else begin
        logic [AW-1:0] ea; ea = addr_q.pop_front();
        chk(font_addr == ea, "R9 font address", {13'h0, font_addr}, {13'h0, ea});
      end
    end
    if (fill_valid) begin
      fill_seen++;
      if (fill_q.size() == 0) chk(0, "R9 extra fill byte", {24'h0, fill_data}, 32'h0);
      else begin
        logic [7:0] ef; ef = fill_q.pop_front();
        chk(fill_data == ef, "R9 fill byte", {24'h0, fill_data}, {24'h0, ef});
      end
    end
    if (dma_done) begin
      done_seen++;
      chk(prev_fill && !fill_valid && fill_q.size() == 0, "R10 done after last byte",
          {31'h0, prev_fill}, 32'h1);
    end
    prev_fill = fill_valid;
  end

  task automatic imm(input bit wr, input logic [1:0] sz, input logic [31:0] d);
    bit acc;
    @(posedge clk); #1;
    xfer_valid = 1; xfer_write = wr; xfer_size = sz; xfer_data = d;
    do begin
      @(negedge clk); acc = xfer_ready;
      @(posedge clk); #1;
    end while (!acc);
    xfer_valid = 0;
    if (wr && sel) begin
      if (d == 32'hA001_0000) armed_m = 1;
      else if (armed_m)
        for (int k = 0; k <= int'(sz); k++) con_q.push_back(d[31-8*k -: 8]);
    end
  endtask

  task automatic dma(input logic [31:0] off, input logic [LEN_W-1:0] n);
    bit acc;
    logic [25:0] idx;
    @(posedge clk); #1;
    dma_req = 1; dma_offset = off; dma_len = n;
    do begin
      @(negedge clk); acc = dma_ready;
      @(posedge clk); #1;
    end while (!acc);
    dma_req = 0;
    if (off[31:6] >= 26'h1AFF00 && off[31:6] < 26'h1FFF00 && n != 0) begin
      idx = off[31:6] - 26'h1AFF00;
      for (int k = 0; k < int'(n); k++) begin
        addr_q.push_back(AW'(idx + 26'(k)));
        fill_q.push_back(rom_f(AW'(idx + 26'(k))));
      end
    end
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    int c0, s0, r0, f0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(xfer_ready && dma_ready, "R1 ready after reset", {30'h0, xfer_ready, dma_ready}, 32'h3);
    chk(!con_valid && !con_flush && !sram_req && !font_rd_en && !fill_valid && !dma_done,
        "R1 outputs quiet", {26'h0, con_valid, con_flush, sram_req, font_rd_en, fill_valid, dma_done}, 32'h0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 32'h0);

    // R12 arming while unselected is ignored
    imm(1, 2'd3, 32'hA001_0000);
    imm(1, 2'd3, 32'h7071_7273);
    imm(0, 2'd3, 32'h2001_0000);
    idle_wait(4);
    chk(con_seen == 0 && !con_valid, "R12 no bytes while unselected", con_seen, 0);
    chk(rd_data == 0, "R12 read ignored while unselected", rd_data, 32'h0);

    sel = 1;
    // R6 idle writes emit nothing
    imm(1, 2'd3, 32'h1122_3344);
    idle_wait(4);
    chk(con_seen == 0, "R6 idle write silent", con_seen, 0);
    // R7 other read leaves rd_data
    imm(0, 2'd3, 32'h1234_5678);
    @(negedge clk);
    chk(rd_data == 0, "R7 unknown read unchanged", rd_data, 32'h0);
    imm(0, 2'd0, 32'h2001_0000);
    @(negedge clk);
    chk(rd_data == 32'h0300_0000, "R7 query reply", rd_data, 32'h0300_0000);
    imm(0, 2'd1, 32'hA001_0000);
    @(negedge clk);
    chk(rd_data == 32'h0300_0000, "R7 other read keeps reply", rd_data, 32'h0300_0000);

    // R2 arm, then R3 unpacking
    imm(1, 2'd3, 32'hA001_0000);
    idle_wait(3);
    chk(con_seen == 0 && !con_valid, "R2 arm word silent", con_seen, 0);
    imm(1, 2'd3, 32'hDEAD_BEEF);
    imm(1, 2'd0, 32'h41FF_FFFF);
    imm(1, 2'd1, 32'h4243_0000);
    imm(1, 2'd3, 32'hA001_0000);
    imm(1, 2'd2, 32'h4445_4600);
    idle_wait(8);
    chk(con_seen == 10 && con_q.size() == 0, "R3 byte count", con_seen, 10);

    // R4 stall with sink blocked
    ready_mode = 2;
    imm(1, 2'd1, 32'h6162_6364);
    @(negedge clk);
    chk(!xfer_ready && con_valid && con_data == 8'h61, "R4 held byte stalls engine",
        {23'h0, xfer_ready, con_data}, {23'h0, 1'b0, 8'h61});
    idle_wait(3);
    @(negedge clk);
    chk(con_valid && con_data == 8'h61 && !xfer_ready, "R4 byte held stable",
        {23'h0, con_valid, con_data}, {23'h0, 1'b1, 8'h61});

    // R9/R3 concurrent console and font paths, random throttle
    ready_mode = 1;
    fork
      begin
        imm(1, 2'd3, 32'h3031_3233);
        imm(1, 2'd2, 32'h3435_3600);
        imm(1, 2'd3, 32'h3738_3940);
      end
      begin
        dma(32'h06C0_0040, 12'd5);
      end
    join
    ready_mode = 0;
    idle_wait(12);
    chk(con_q.size() == 0, "R3 concurrent console drained", con_q.size(), 0);
    chk(fill_q.size() == 0 && addr_q.size() == 0, "R9 concurrent font drained", fill_q.size(), 0);

    // R5 deselect
    sel = 0;
    armed_m = 0;
    idle_wait(4);
    chk(flush_seen == 1, "R5 single flush", flush_seen, 1);
    sel = 1;
    c0 = con_seen;
    imm(1, 2'd3, 32'h5152_5354);
    idle_wait(5);
    chk(con_seen == c0, "R5 idle after deselect", con_seen, c0);
    chk(flush_seen == 1, "R5 no flush when idle", flush_seen, 1);

    // R9 window edges, R10 done
    dma(32'h06BF_C000, 12'd4);
    dma(32'h07FF_BFC0, 12'd1);
    dma(32'h06BF_C0FF, 12'd2);
    idle_wait(10);
    chk(done_seen == 4, "R10 done count", done_seen, 4);
    chk(fill_seen == 12 && fill_q.size() == 0, "R9 fill count", fill_seen, 12);

    // R8 SRAM
    r0 = rd_seen; s0 = sram_seen;
    dma(32'h2000_0100, 12'd8);
    idle_wait(5);
    chk(sram_seen == s0 + 1, "R8 sram strobe", sram_seen, s0 + 1);
    chk(rd_seen == r0, "R8 no font read", rd_seen, r0);

    // R11 ignored offsets
    f0 = fill_seen;
    dma(32'h07FF_C000, 12'd3);
    dma(32'h06BF_BFC0, 12'd3);
    dma(32'h1234_5678, 12'd3);
    dma(32'h06C0_0000, 12'd0);
    idle_wait(6);
    chk(fill_seen == f0 && rd_seen == r0 && sram_seen == s0 + 1 && done_seen == 4,
        "R11 ignored requests", fill_seen, f0);
    @(negedge clk);
    chk(dma_ready, "R11 ready stays high", {31'h0, dma_ready}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule